// File: doc/BRIEF.md
# EDID Register Read Controller

This block is a memory-mapped slave. To software it looks like a display I2C host controller. It does not drive bus wires. It answers reads from a 128-byte EDID image that arrives on an input vector. Software picks a display port through a port-select register and writes a command word. It then fetches the image four bytes at a time through a data register and watches progress in a status register.

The bus phase (idle, data, wait) and the byte pointer move only in response to register accesses. The last data read of a transfer ends the phase. The cycle type stored in the command decides where it ends: in idle for the types that carry a stop, and in the wait phase for the others. Two inputs per port control whether EDID is available on that port: a monitor-present flag and a DP flag.

Registers sit at word addresses 0 (port select), 1 (command), 2 (status) and 3 (data). Read data is registered and appears on `rdata` the cycle after `rd_en`. A cycle with `wr_en` high is a write and ignores `rd_en`.

Top module: `edid_host_regs`

## Requirements
- R1: After reset, status reads 0x0000_0C00 (ready bit 11 and error bit 10 set). Port select, command and data read 0. A read's value appears on `rdata` one cycle after `rd_en`.
- R2: A port-select write stores pin field bits 2:0, which reads back. A pin p with 1 <= p <= NPORTS selects port p-1. It sets ready (bit 11) and wait (bit 14) and clears active (bit 9). It clears error (bit 10) only if `mon_present[p-1]` is 1 and `mon_is_dp[p-1]` is 0; otherwise it sets error. Pin 0, or a pin above NPORTS, only drops the current selection and EDID availability, and leaves the status bits unchanged.
- R3: Command fields are: bit 0 read direction, bits 7:1 target address, bits 15:8 index, bits 24:16 byte total, bits 27:25 cycle type and bit 31 software clear. Bit 30 is never stored and always reads back 0.
- R4: Target address 7'h50 selects the EDID image. Any other nonzero address is ignored, and reads then return zero bytes. Address 0 leaves the selection as it was.
- R5: Cycle types 1, 3, 5 and 7 enter the data phase: active is set and wait is cleared. Types 3 and 7 (bit 26 set) load the byte pointer from the index field.
- R6: Cycle type 4 (stop) acts only when the stored cycle field was nonzero. It then clears selection, pointer and total, returns to idle, and clears active and wait. Otherwise it has no effect on phase or selection.
- R7: When bit 0 of the stored command is 1, a data read takes n = min(4, total - pointer) bytes. Byte i goes to bits 8i+7:8i, and lanes n..3 keep their previous contents. The pointer advances past each byte served.
- R8: A data read with 4 or fewer bytes left ends the transfer and clears the selection. Cycle types with bit 27 set go to idle (wait bit 0); the others go to wait (bit 14 set). Active is cleared. Later data reads return the last word unchanged.
- R9: A byte at offset 128 or above, or any byte while nothing is selected or no EDID is available, reads as 0 and does not advance the pointer.
- R10: A status read returns the value before the read and then sets in-use (bit 15). A status write with bit 15 set clears in-use. All other status bits ignore writes.
- R11: A command write with bit 31 set, while the stored bit 31 is 0, sets ready and is decoded normally. While the stored bit 31 is 1, command writes with bit 31 set are ignored. A write with bit 31 clear then clears the stored bit 31 and sets status to ready, plus error if no EDID is available. The phase returns to idle.
- R12: A data read while the stored read-direction bit is 0 returns the last data word and leaves the pointer unchanged. Writes to the data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (ignored when wr_en is high) |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rom_image | input | ROM_BYTES*8 | EDID image, byte k at bits 8k+7:8k |
| mon_present | input | NPORTS | Monitor attached on each port |
| mon_is_dp | input | NPORTS | Port carries a DP monitor |

## Verification
The bench targets these corner cases:
- A final word shorter than four bytes. A design that zeroes the upper lanes, instead of keeping them, shows wrong upper bytes.
- A transfer that crosses byte 128. Reading past the image shows up as nonzero lanes.
- A stop written while the stored cycle field is zero, and a stop written after a transfer. A design that ignores the stored cycle field either drops a live selection or keeps a dead one.
- The software-clear sequence, writes with the read-direction bit clear, and the in-use handshake. A mistake in any of these appears as wrong status bits, a moved pointer, or a data word that changed when it should not.

// File: rtl/edid_host_pkg.sv
package edid_host_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam int ST_ACTIVE = 9;
    localparam int ST_ERROR  = 10;
    localparam int ST_READY  = 11;
    localparam int ST_WAIT   = 14;
    localparam int ST_INUSE  = 15;

    localparam int CMD_DIR   = 0;
    localparam int CMD_INDEX = 26;
    localparam int CMD_STOPB = 27;
    localparam int CMD_SWRDY = 30;
    localparam int CMD_SWCLR = 31;

    localparam logic [2:0] CYC_NONE = 3'd0;
    localparam logic [2:0] CYC_STOP = 3'd4;

    localparam logic [1:0] RA_PORT = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

endpackage

// File: rtl/edid_port_map.sv
module edid_port_map #(
    parameter int NPORTS = 4,
    parameter int PORT_W = 2
) (
    input  logic [2:0]        pin,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    always_comb begin
        hit  = (pin != 3'd0) && (int'(pin) <= NPORTS);
        port = PORT_W'(pin - 3'd1);
    end
endmodule

// File: rtl/edid_lane_fetch.sv
module edid_lane_fetch #(
    parameter int ROM_BYTES = 128,
    parameter int PTR_W     = 10,
    parameter int LANES     = 4,
    localparam int CW       = $clog2(LANES + 1),
    localparam int IDX_W    = $clog2(ROM_BYTES)
) (
    input  logic [ROM_BYTES*8-1:0] rom,
    input  logic [PTR_W-1:0]       ptr,
    input  logic [CW-1:0]          take_n,
    input  logic                   src_ok,
    output logic [LANES-1:0]       lane_wr,
    output logic [LANES*8-1:0]     lane_bytes,
    output logic [CW-1:0]          got
);
    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PTR_W:0]   pos;
        logic             in_rom;
        logic [IDX_W-1:0] idx;
        always_comb begin
            pos        = {1'b0, ptr} + (PTR_W + 1)'(g);
            in_rom     = pos < (PTR_W + 1)'(ROM_BYTES);
            idx        = in_rom ? pos[IDX_W-1:0] : '0;
            lane_wr[g] = CW'(g) < take_n;
            lane_ok[g] = lane_wr[g] && src_ok && in_rom;
            lane_bytes[8*g +: 8] = lane_ok[g] ? rom[{idx, 3'b000} +: 8] : 8'h00;
        end
    end

    assign got = CW'($countones(lane_ok));
endmodule

// File: rtl/edid_host_regs.sv
module edid_host_regs
    import edid_host_pkg::*;
#(
    parameter int         ROM_BYTES = 128,
    parameter int         NPORTS    = 4,
    parameter logic [6:0] EDID_ADDR = 7'h50
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [1:0]             addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    input  logic [ROM_BYTES*8-1:0] rom_image,
    input  logic [NPORTS-1:0]      mon_present,
    input  logic [NPORTS-1:0]      mon_is_dp
);
    localparam int DW     = 32;
    localparam int LANES  = DW / 8;
    localparam int CW     = $clog2(LANES + 1);
    localparam int CNT_W  = 9;
    localparam int PTR_W  = CNT_W + 1;
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    typedef struct packed {
        logic [2:0]        pin;
        logic [DW-1:0]     cmd;
        logic [DW-1:0]     stat;
        logic [DW-1:0]     data;
        logic [DW-1:0]     rdata;
        phase_e            phase;
        logic              sel;
        logic              avail;
        logic [PORT_W-1:0] port;
        logic [PTR_W-1:0]  ptr;
        logic [CNT_W-1:0]  total;
    } st_t;

    st_t q, d;

    function automatic st_t wipe(st_t s);
        st_t r = s;
        r.sel   = 1'b0;
        r.avail = 1'b0;
        r.port  = '0;
        r.ptr   = '0;
        r.total = '0;
        return r;
    endfunction

    // port select decode
    logic              pm_hit;
    logic [PORT_W-1:0] pm_port;
    edid_port_map #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_port_map (
        .pin  (wdata[2:0]),
        .hit  (pm_hit),
        .port (pm_port)
    );

    // remaining byte count, sign in the top bit
    logic [PTR_W:0] rem;
    logic           rem_live, rem_le4;
    logic [CW-1:0]  take_n;
    always_comb begin
        rem      = {2'b00, q.total} - {1'b0, q.ptr};
        rem_live = !rem[PTR_W] && (rem != '0);
        rem_le4  = rem[PTR_W] || (rem[PTR_W-1:0] <= PTR_W'(LANES));
        take_n   = !rem_live ? '0 : (rem_le4 ? CW'(rem[2:0]) : CW'(LANES));
    end

    logic [LANES-1:0]    lane_wr;
    logic [LANES*8-1:0]  lane_bytes;
    logic [CW-1:0]       got;
    logic                src_ok;
    assign src_ok = q.sel && q.avail && mon_present[q.port];

    edid_lane_fetch #(.ROM_BYTES(ROM_BYTES), .PTR_W(PTR_W), .LANES(LANES)) u_fetch (
        .rom        (rom_image),
        .ptr        (q.ptr),
        .take_n     (take_n),
        .src_ok     (src_ok),
        .lane_wr    (lane_wr),
        .lane_bytes (lane_bytes),
        .got        (got)
    );

    logic [DW-1:0] nword;
    logic [DW-1:0] cmd_w;

    always_comb begin
        d     = q;
        cmd_w = wdata & ~(DW'(1) << CMD_SWRDY);
        nword = q.data;
        for (int i = 0; i < LANES; i++) begin
            if (lane_wr[i]) nword[8*i +: 8] = lane_bytes[8*i +: 8];
        end

        if (wr_en) begin
            case (addr)
                RA_PORT: begin
                    d.pin = wdata[2:0];
                    d     = wipe(d);
                    if (pm_hit) begin
                        d.phase           = PH_IDLE;
                        d.stat[ST_ACTIVE] = 1'b0;
                        d.stat[ST_READY]  = 1'b1;
                        d.stat[ST_WAIT]   = 1'b1;
                        if (mon_present[pm_port] && !mon_is_dp[pm_port]) begin
                            d.port           = pm_port;
                            d.avail          = 1'b1;
                            d.stat[ST_ERROR] = 1'b0;
                        end else begin
                            d.stat[ST_ERROR] = 1'b1;
                        end
                    end
                end
                RA_CMD: begin
                    if (q.cmd[CMD_SWCLR]) begin
                        if (!wdata[CMD_SWCLR]) begin
                            d.cmd[CMD_SWCLR]  = 1'b0;
                            d.stat            = '0;
                            d.stat[ST_READY]  = 1'b1;
                            d.stat[ST_ERROR]  = !q.avail;
                            d.phase           = PH_IDLE;
                        end
                    end else begin
                        if (wdata[CMD_SWCLR]) d.stat[ST_READY] = 1'b1;
                        d.total = cmd_w[24:16];
                        if (cmd_w[7:1] == EDID_ADDR) d.sel = 1'b1;
                        if (cmd_w[CMD_INDEX]) d.ptr = PTR_W'(cmd_w[15:8]);
                        if (cmd_w[27:25] == CYC_STOP) begin
                            if (q.cmd[27:25] != CYC_NONE) begin
                                d                 = wipe(d);
                                d.phase           = PH_IDLE;
                                d.stat[ST_ACTIVE] = 1'b0;
                                d.stat[ST_WAIT]   = 1'b0;
                            end
                        end else if (cmd_w[25]) begin
                            d.phase           = PH_DATA;
                            d.stat[ST_ACTIVE] = 1'b1;
                            d.stat[ST_WAIT]   = 1'b0;
                        end
                        d.cmd = cmd_w;
                    end
                end
                RA_STAT: begin
                    if (wdata[ST_INUSE]) d.stat[ST_INUSE] = 1'b0;
                end
                default: ;
            endcase
        end else if (rd_en) begin
            case (addr)
                RA_PORT: d.rdata = DW'(q.pin);
                RA_CMD:  d.rdata = q.cmd;
                RA_STAT: begin
                    d.rdata          = q.stat;
                    d.stat[ST_INUSE] = 1'b1;
                end
                default: begin
                    if (q.cmd[CMD_DIR] && rem_live) begin
                        d.data  = nword;
                        d.rdata = nword;
                        d.ptr   = q.ptr + PTR_W'(got);
                        if (rem_le4) begin
                            d                 = wipe(d);
                            d.phase           = q.cmd[CMD_STOPB] ? PH_IDLE : PH_WAIT;
                            d.stat[ST_ACTIVE] = 1'b0;
                            d.stat[ST_WAIT]   = !q.cmd[CMD_STOPB];
                        end
                    end else begin
                        d.rdata = q.data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q                 <= '0;
            q.phase           <= PH_IDLE;
            q.stat[ST_READY]  <= 1'b1;
            q.stat[ST_ERROR]  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;

    // active flag follows the data phase
    assert_active_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.stat[ST_ACTIVE] == (q.phase == PH_DATA));

    assert_inuse_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == RA_STAT) |=> q.stat[ST_INUSE]);

    assert_inuse_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_STAT && wdata[ST_INUSE]) |=> !q.stat[ST_INUSE]);

    assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_CMD && !q.cmd[CMD_SWCLR] && wdata[27:25] == CYC_STOP
         && q.cmd[27:25] != CYC_NONE) |=> (q.phase == PH_IDLE && !q.sel));

    assert_avail_no_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.avail |-> !q.stat[ST_ERROR]);

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == RA_DATA) |=>
        (q.ptr == '0 || (q.ptr >= $past(q.ptr) && q.ptr <= $past(q.ptr) + PTR_W'(LANES))));
endmodule

// File: tb/test_edid_host_regs.sv
module test_edid_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 128;
    localparam logic [31:0] STM = 32'h0000_7E00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NB*8-1:0] rom;
    logic [3:0] mon_present = 4'b0111;
    logic [3:0] mon_is_dp   = 4'b0010;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edid_host_regs i_edid_host_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rom_image(rom),
        .mon_present(mon_present), .mon_is_dp(mon_is_dp)
    );

    function automatic logic [7:0] rb(int k);
        return (k < NB) ? rom[k*8 +: 8] : 8'h00;
    endfunction

    function automatic logic [31:0] cw(bit rd, logic [6:0] a, logic [7:0] idx,
                                       logic [8:0] tot, logic [2:0] cyc);
        return {4'b0, cyc, tot, idx, a, rd};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, logic [31:0] mask);
        checks++;
        if ((act & mask) !== (exp & mask)) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h mask=%08h", req, act, exp, mask);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e, w1, w;
        void'($urandom(32'd20240607));
        for (int k = 0; k < NB; k++) rom[k*8 +: 8] = 8'($urandom);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 in-use handshake
        rd(2'd2, v); chk("R1 status after reset", v, 32'h0C00, '1);
        rd(2'd2, v); chk("R10 in-use after read", v, 32'h8C00, '1);
        wr(2'd2, 32'h8000);
        rd(2'd2, v); chk("R10 in-use cleared", v, 32'h0C00, '1);
        wr(2'd2, 32'h0FFF);
        rd(2'd2, v); chk("R10 other bits read-only", v, 32'h8C00, '1);
        rd(2'd1, v); chk("R1 command reset", v, 32'h0, '1);
        rd(2'd0, v); chk("R1 port reset", v, 32'h0, '1);
        rd(2'd3, v); chk("R1 data reset", v, 32'h0, '1);

        // R2 port select
        wr(2'd0, 32'd2); rd(2'd2, v); chk("R2 DP port error", v, 32'h4C00, STM);
        wr(2'd0, 32'd4); rd(2'd2, v); chk("R2 absent port error", v, 32'h4C00, STM);
        wr(2'd0, 32'd1); rd(2'd2, v); chk("R2 good port", v, 32'h4800, STM);
        wr(2'd0, 32'd6); rd(2'd2, v); chk("R2 invalid pin no status change", v, 32'h4800, STM);
        rd(2'd0, v); chk("R2 pin readback", v, 32'd6, '1);

        // R3/R5/R7/R8 indexed no-stop transfer with a short tail
        wr(2'd0, 32'd1);
        e = cw(1, 7'h50, 8'd4, 9'd10, 3'd3);
        wr(2'd1, e | 32'h4000_0000);
        rd(2'd1, v); chk("R3 command readback, bit30 dropped", v, e, '1);
        rd(2'd2, v); chk("R5 data phase active", v, 32'h0A00, STM);
        rd(2'd3, w1); chk("R7 full word", w1, {rb(7), rb(6), rb(5), rb(4)}, '1);
        rd(2'd3, v); chk("R7 short tail keeps upper lanes", v, {rb(7), rb(6), rb(9), rb(8)}, '1);
        rd(2'd2, w); chk("R8 no-stop ends in wait", w, 32'h4800, STM);
        rd(2'd3, w); chk("R8 later read unchanged", w, v, '1);

        // R8 stop-type, non-indexed
        wr(2'd0, 32'd1);
        wr(2'd1, cw(1, 7'h50, 8'd0, 9'd5, 3'd5));
        rd(2'd3, v); chk("R7 word from zero", v, {rb(3), rb(2), rb(1), rb(0)}, '1);
        rd(2'd3, v); chk("R7 one-byte tail", v, {rb(3), rb(2), rb(1), rb(4)}, '1);
        rd(2'd2, v); chk("R8 stop ends idle", v, 32'h0800, STM);

        // R9 crossing end of image
        wr(2'd0, 32'd1);
        wr(2'd1, cw(1, 7'h50, 8'd126, 9'd130, 3'd7));
        rd(2'd3, v); chk("R9 beyond 128 reads zero", v, {16'h0, rb(127), rb(126)}, '1);

        // R4/R9 wrong address
        wr(2'd0, 32'd1);
        wr(2'd1, cw(1, 7'h51, 8'd0, 9'd8, 3'd3));
        rd(2'd3, v); chk("R4 foreign address serves zeros", v, 32'h0, '1);
        rd(2'd3, v); chk("R9 no selection no advance", v, 32'h0, '1);
        rd(2'd2, v); chk("R9 transfer still active", v, 32'h0A00, STM);
        wr(2'd1, cw(1, 7'h00, 8'd0, 9'd0, 3'd4));
        rd(2'd2, v); chk("R6 stop returns idle", v, 32'h0800, STM);

        // R6 stop ignored when stored cycle is zero; R4 address zero keeps selection
        wr(2'd0, 32'd1);
        wr(2'd1, cw(0, 7'h50, 8'd0, 9'd0, 3'd0));
        wr(2'd1, cw(0, 7'h00, 8'd0, 9'd0, 3'd4));
        wr(2'd1, cw(1, 7'h00, 8'd0, 9'd4, 3'd3));
        rd(2'd3, v); chk("R6 ignored stop keeps selection (R4)", v, {rb(3), rb(2), rb(1), rb(0)}, '1);
        wr(2'd0, 32'd1);
        wr(2'd1, cw(0, 7'h50, 8'd0, 9'd8, 3'd1));
        wr(2'd1, cw(0, 7'h00, 8'd0, 9'd0, 3'd4));
        rd(2'd2, v); chk("R6 stop after transfer idle", v, 32'h0800, STM);
        wr(2'd1, cw(1, 7'h00, 8'd0, 9'd4, 3'd3));
        rd(2'd3, v); chk("R6 stop cleared selection", v, 32'h0, '1);

        // R12 direction bit and data writes
        wr(2'd0, 32'd1);
        wr(2'd1, cw(0, 7'h50, 8'd0, 9'd8, 3'd3));
        wr(2'd3, 32'h1234_5678);
        rd(2'd3, v); chk("R12 write-direction read returns last word", v, 32'h0, '1);
        wr(2'd1, cw(1, 7'h00, 8'd0, 9'd8, 3'd1));
        rd(2'd3, v); chk("R12 pointer did not move", v, {rb(3), rb(2), rb(1), rb(0)}, '1);

        // R11 software clear
        wr(2'd0, 32'd1);
        wr(2'd1, cw(1, 7'h50, 8'd0, 9'd8, 3'd3));
        wr(2'd1, 32'h8000_0000);
        rd(2'd2, v); chk("R11 clear bit keeps active", v, 32'h0A00, STM);
        rd(2'd1, v); chk("R11 clear bit stored", v, 32'h8000_0000, '1);
        wr(2'd1, 32'h8000_0000 | cw(1, 7'h50, 8'd0, 9'd8, 3'd5));
        rd(2'd1, v); chk("R11 writes ignored while set", v, 32'h8000_0000, '1);
        wr(2'd1, 32'h0);
        rd(2'd2, v); chk("R11 release resets status", v, 32'h0800, '1);
        rd(2'd1, v); chk("R11 clear bit released", v, 32'h0, '1);
        wr(2'd0, 32'd4);
        wr(2'd1, 32'h8000_0000);
        wr(2'd1, 32'h0);
        rd(2'd2, v); chk("R11 release with no EDID sets error", v, 32'h0C00, '1);

        // random transfers
        for (int it = 0; it < 40; it++) begin
            int idx = int'($urandom % 100);
            int len = 1 + int'($urandom % 28);
            bit stp = bit'($urandom % 2);
            int nr  = (len + 3) / 4;
            wr(2'd0, ($urandom % 2) ? 32'd1 : 32'd3);
            wr(2'd1, cw(1, 7'h50, 8'(idx), 9'(idx + len), stp ? 3'd7 : 3'd3));
            for (int r = 0; r < nr; r++) begin
                int n = (len - 4*r > 4) ? 4 : len - 4*r;
                logic [31:0] m = '0;
                e = '0;
                for (int i = 0; i < n; i++) begin
                    e[8*i +: 8] = rb(idx + 4*r + i);
                    m[8*i +: 8] = 8'hFF;
                end
                rd(2'd3, v); chk("R7 random word", v, e, m);
            end
            rd(2'd2, w); chk("R8 random end phase", w, stp ? 32'h0800 : 32'h4800, STM);
            rd(2'd3, w); chk("R8 random word held", w, v, '1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule